// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two component predictors run side by side. The first is a table of 2-bit counters selected by a 12-bit register that records the outcomes of the most recently resolved branches. The second works in two levels. A table of per-branch 10-bit outcome histories is selected by the branch address, and the history it returns picks one of a table of 3-bit counters. A third table of 2-bit counters, also selected by the global outcome register, decides which component's guess to use.

Fetch presents the PC bits that matter on the lookup port. In the same cycle it receives the final direction, both component guesses, the chooser's pick, and the two history values that were used as indices. When the branch resolves, the pipeline returns the outcome together with those saved history values on the update port, and every table is trained at that moment. After a mispredict, the global outcome register can be reloaded with a corrected value.

Top module: `tournament_predictor`

## Requirements
- R1: After reset, every global and chooser counter holds 1, every local counter holds 3, and every history is zero. Lookups then return not-taken, local chosen, and zero for both history outputs.
- R2: The global outcome register is 12 bits wide. Bit 0 holds the most recent resolved outcome (1 = taken). Each update shifts the register left by one and inserts the new outcome at bit 0.
- R3: A restore loads the global outcome register with the supplied value on the next clock edge. A restore overrides any update shift in that same cycle.
- R4: The per-branch history table has 1024 entries of 10 bits, selected by PC bits 11:2. An update shifts that branch's outcome into bit 0 of its entry. A lookup reports the entry as the local history.
- R5: Global counters are 2 bits and are selected by the saved global history. They predict taken at values 2 and 3. They count up on taken and down on not-taken, saturating at 0 and 3.
- R6: Local counters are 3 bits and are selected by the saved local history. They predict taken at values 4 through 7. They count up on taken and down on not-taken, saturating at 0 and 7.
- R7: Chooser counters are 2 bits and are selected by the saved global history. A value of 2 or more picks the global guess. A chooser counter is trained only when the two component guesses disagree. It steps toward the correct one (up for global, down for local) and saturates at 0 and 3.
- R8: The final prediction equals the guess of the component the chooser picks.
- R9: Cycles with neither update nor restore leave all predictor state unchanged.
- R10: A lookup in the same cycle as an update sees the state from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupPc | input | 10 | Fetch PC bits 11:2 of the branch being predicted |
| predTaken | output | 1 | Final direction prediction |
| predGlobalTaken | output | 1 | Guess of the global component |
| predLocalTaken | output | 1 | Guess of the local component |
| predUseGlobal | output | 1 | Chooser picks the global component |
| predGhist | output | 12 | Global history used for this lookup |
| predLocalHist | output | 10 | Local history used for this lookup |
| updValid | input | 1 | A branch resolved this cycle |
| updPc | input | 10 | PC bits 11:2 of the resolved branch |
| updTaken | input | 1 | Resolved outcome |
| updGhist | input | 12 | Global history saved at lookup time |
| updLocalHist | input | 10 | Local history saved at lookup time |
| restoreValid | input | 1 | Reload the global history |
| restoreGhist | input | 12 | Value to reload |

## Verification
The bench drives one branch many times in the same direction, then reverses it once. A counter that wraps instead of saturating would flip the next guess, and a counter that saturates too early would miss the change in the local history pattern. Restores are mixed with updates, including restores and updates in the same cycle. A design that let the shift win, or that shifted the restored value, would report the wrong history from then on. Branches that alias in the chooser are mixed with agreeing and disagreeing components, so a chooser that trained on agreement or moved the wrong way would pick the wrong component. Idle stretches check that lookups alone leave the state untouched. Every cycle also checks that a same-cycle update does not leak into the lookup result.

// File: rtl/tp_pkg.sv
package tp_pkg;
  // Strobes from the control to the table datapath
  typedef struct packed {
    logic gInc;
    logic gDec;
    logic lInc;
    logic lDec;
    logic cInc;
    logic cDec;
    logic histShift;
    logic histRestore;
  } tpStrobe_t;
endpackage

// File: rtl/tp_datapath.sv
module tp_datapath
  import tp_pkg::*;
#(
  parameter int GHIST_W   = 12,
  parameter int LHT_IDX_W = 10,
  parameter int LHIST_W   = 10,
  parameter int GCTR_W    = 2,
  parameter int LCTR_W    = 3,
  parameter int CCTR_W    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tpStrobe_t            strb,
  input  logic                 updTaken,
  input  logic [LHT_IDX_W-1:0] lkLhtIdx,
  input  logic [LHT_IDX_W-1:0] updLhtIdx,
  input  logic [GHIST_W-1:0]   updGhist,
  input  logic [LHIST_W-1:0]   updLocalHist,
  input  logic [GHIST_W-1:0]   restoreGhist,
  output logic [GHIST_W-1:0]   ghist,
  output logic [LHIST_W-1:0]   lkLocalHist,
  output logic                 lkGPred,
  output logic                 lkLPred,
  output logic                 lkCPred,
  output logic                 updGPred,
  output logic                 updLPred
);
  localparam int G_DEPTH = 1 << GHIST_W;
  localparam int L_DEPTH = 1 << LHIST_W;
  localparam int H_DEPTH = 1 << LHT_IDX_W;
  localparam logic [GCTR_W-1:0] G_WEAK = GCTR_W'((1 << (GCTR_W-1)) - 1);
  localparam logic [LCTR_W-1:0] L_WEAK = LCTR_W'((1 << (LCTR_W-1)) - 1);
  localparam logic [CCTR_W-1:0] C_WEAK = CCTR_W'((1 << (CCTR_W-1)) - 1);
  localparam logic [GCTR_W-1:0] G_MAX  = '1;
  localparam logic [LCTR_W-1:0] L_MAX  = '1;
  localparam logic [CCTR_W-1:0] C_MAX  = '1;

  logic [GCTR_W-1:0]  gTab   [G_DEPTH];
  logic [CCTR_W-1:0]  cTab   [G_DEPTH];
  logic [LCTR_W-1:0]  lTab   [L_DEPTH];
  logic [LHIST_W-1:0] lhtTab [H_DEPTH];

  logic [GCTR_W-1:0] gCur;
  logic [LCTR_W-1:0] lCur;
  logic [CCTR_W-1:0] cCur;

  // Lookup side: combinational reads of the current state
  always_comb begin
    lkLocalHist = lhtTab[lkLhtIdx];
    lkLPred     = lTab[lkLocalHist][LCTR_W-1];
    lkGPred     = gTab[ghist][GCTR_W-1];
    lkCPred     = cTab[ghist][CCTR_W-1];
  end

  // Update side: counters at the saved indices
  always_comb begin
    gCur     = gTab[updGhist];
    lCur     = lTab[updLocalHist];
    cCur     = cTab[updGhist];
    updGPred = gCur[GCTR_W-1];
    updLPred = lCur[LCTR_W-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < G_DEPTH; i++) begin
        gTab[GHIST_W'(i)] <= G_WEAK;
        cTab[GHIST_W'(i)] <= C_WEAK;
      end
      for (int i = 0; i < L_DEPTH; i++) lTab[LHIST_W'(i)] <= L_WEAK;
      for (int i = 0; i < H_DEPTH; i++) lhtTab[LHT_IDX_W'(i)] <= '0;
      ghist <= '0;
    end else begin
      if (strb.gInc && gCur != G_MAX)     gTab[updGhist] <= gCur + 1'b1;
      else if (strb.gDec && gCur != '0)   gTab[updGhist] <= gCur - 1'b1;

      if (strb.lInc && lCur != L_MAX)     lTab[updLocalHist] <= lCur + 1'b1;
      else if (strb.lDec && lCur != '0)   lTab[updLocalHist] <= lCur - 1'b1;

      if (strb.cInc && cCur != C_MAX)     cTab[updGhist] <= cCur + 1'b1;
      else if (strb.cDec && cCur != '0)   cTab[updGhist] <= cCur - 1'b1;

      if (strb.histShift)
        lhtTab[updLhtIdx] <= {lhtTab[updLhtIdx][LHIST_W-2:0], updTaken};

      if (strb.histRestore)    ghist <= restoreGhist;
      else if (strb.histShift) ghist <= {ghist[GHIST_W-2:0], updTaken};
    end
  end

  // Global counter strobes never conflict
  assert_gstrobe_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.gInc, strb.gDec}));
  // Local counter strobes never conflict
  assert_lstrobe_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.lInc, strb.lDec}));
  // Restore loads the supplied value
  assert_restore_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.histRestore |=> ghist == $past(restoreGhist));
  // Update puts the newest outcome at bit 0
  assert_hist_shift_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.histShift && !strb.histRestore) |=>
      (ghist[0] == $past(updTaken)) && (ghist[GHIST_W-1:1] == $past(ghist[GHIST_W-2:0])));
  // Idle cycles hold the global history
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.histShift && !strb.histRestore) |=> $stable(ghist));
endmodule

// File: rtl/tp_control.sv
module tp_control
  import tp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      updValid,
  input  logic      updTaken,
  input  logic      restoreValid,
  input  logic      updGPred,
  input  logic      updLPred,
  output tpStrobe_t strb
);
  logic disagree;

  always_comb begin
    disagree         = updGPred ^ updLPred;
    strb             = '0;
    strb.gInc        = updValid &&  updTaken;
    strb.gDec        = updValid && !updTaken;
    strb.lInc        = updValid &&  updTaken;
    strb.lDec        = updValid && !updTaken;
    strb.cInc        = updValid && disagree && (updGPred == updTaken);
    strb.cDec        = updValid && disagree && (updLPred == updTaken);
    strb.histShift   = updValid;
    strb.histRestore = restoreValid;
  end

  // Chooser moves only when the components disagree
  assert_chooser_disagree_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cInc || strb.cDec) |-> (updGPred != updLPred));
  // Chooser never moves without a resolved branch
  assert_chooser_needs_update_R9: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |-> !(strb.cInc || strb.cDec || strb.gInc || strb.lDec));
endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor
  import tp_pkg::*;
#(
  parameter int GHIST_W   = 12,
  parameter int LHT_IDX_W = 10,
  parameter int LHIST_W   = 10,
  parameter int GCTR_W    = 2,
  parameter int LCTR_W    = 3,
  parameter int CCTR_W    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LHT_IDX_W+1:2] lookupPc,
  output logic                 predTaken,
  output logic                 predGlobalTaken,
  output logic                 predLocalTaken,
  output logic                 predUseGlobal,
  output logic [GHIST_W-1:0]   predGhist,
  output logic [LHIST_W-1:0]   predLocalHist,
  input  logic                 updValid,
  input  logic [LHT_IDX_W+1:2] updPc,
  input  logic                 updTaken,
  input  logic [GHIST_W-1:0]   updGhist,
  input  logic [LHIST_W-1:0]   updLocalHist,
  input  logic                 restoreValid,
  input  logic [GHIST_W-1:0]   restoreGhist
);
  tpStrobe_t strb;
  logic updGPred, updLPred;

  tp_control u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .updValid     (updValid),
    .updTaken     (updTaken),
    .restoreValid (restoreValid),
    .updGPred     (updGPred),
    .updLPred     (updLPred),
    .strb         (strb)
  );

  tp_datapath #(
    .GHIST_W(GHIST_W), .LHT_IDX_W(LHT_IDX_W), .LHIST_W(LHIST_W),
    .GCTR_W(GCTR_W), .LCTR_W(LCTR_W), .CCTR_W(CCTR_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .updTaken     (updTaken),
    .lkLhtIdx     (lookupPc),
    .updLhtIdx    (updPc),
    .updGhist     (updGhist),
    .updLocalHist (updLocalHist),
    .restoreGhist (restoreGhist),
    .ghist        (predGhist),
    .lkLocalHist  (predLocalHist),
    .lkGPred      (predGlobalTaken),
    .lkLPred      (predLocalTaken),
    .lkCPred      (predUseGlobal),
    .updGPred     (updGPred),
    .updLPred     (updLPred)
  );

  assign predTaken = predUseGlobal ? predGlobalTaken : predLocalTaken;

  // Final guess always matches one of the components
  assert_final_pick_R8: assert property (@(posedge clk) disable iff (!rstN)
    (predGlobalTaken == predLocalTaken) |-> (predTaken == predGlobalTaken));
endmodule

// File: tb/tournament_predictor_tb.sv
`timescale 1ns/1ps
module tournament_predictor_tb;
  localparam int GH = 12;
  localparam int LI = 10;
  localparam int LH = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [LI+1:2] lookupPc = '0;
  logic predTaken, predGlobalTaken, predLocalTaken, predUseGlobal;
  logic [GH-1:0] predGhist;
  logic [LH-1:0] predLocalHist;
  logic updValid = 1'b0;
  logic [LI+1:2] updPc = '0;
  logic updTaken = 1'b0;
  logic [GH-1:0] updGhist = '0;
  logic [LH-1:0] updLocalHist = '0;
  logic restoreValid = 1'b0;
  logic [GH-1:0] restoreGhist = '0;

  int checkCount = 0;
  int failCount = 0;

  always #2.5 clk = ~clk;

  tournament_predictor u_dut (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc),
    .predTaken(predTaken), .predGlobalTaken(predGlobalTaken),
    .predLocalTaken(predLocalTaken), .predUseGlobal(predUseGlobal),
    .predGhist(predGhist), .predLocalHist(predLocalHist),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken),
    .updGhist(updGhist), .updLocalHist(updLocalHist),
    .restoreValid(restoreValid), .restoreGhist(restoreGhist)
  );

  // Reference state
  logic [1:0]    gRef   [1 << GH];
  logic [1:0]    cRef   [1 << GH];
  logic [2:0]    lRef   [1 << LH];
  logic [LH-1:0] lhtRef [1 << LI];
  logic [GH-1:0] ghRef;

  function automatic logic [1:0] sat2(logic [1:0] v, bit up);
    if (up) return (v == 2'd3) ? v : v + 2'd1;
    return (v == 2'd0) ? v : v - 2'd1;
  endfunction

  function automatic logic [2:0] sat3(logic [2:0] v, bit up);
    if (up) return (v == 3'd7) ? v : v + 3'd1;
    return (v == 3'd0) ? v : v - 3'd1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checkCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < (1 << GH); i++) begin gRef[i] = 2'd1; cRef[i] = 2'd1; end
    for (int i = 0; i < (1 << LH); i++) lRef[i] = 3'd3;
    for (int i = 0; i < (1 << LI); i++) lhtRef[i] = '0;
    ghRef = '0;
  endtask

  // One cycle: lookup lkIdx, optionally resolve updIdx, optionally restore
  task automatic step(string ph, logic [LI-1:0] lkIdx, bit doUpd,
                      logic [LI-1:0] updIdx, bit tk, bit doRst, logic [GH-1:0] rv);
    logic [GH-1:0] gi;
    logic [LH-1:0] li, lkLh;
    bit eG, eL, eC, eT, uG, uL;
    @(negedge clk);
    lkLh = lhtRef[lkIdx];
    eG = gRef[ghRef][1];
    eL = lRef[lkLh][2];
    eC = cRef[ghRef][1];
    eT = eC ? eG : eL;
    gi = ghRef;
    li = lhtRef[updIdx];
    lookupPc = lkIdx; updValid = doUpd; updPc = updIdx; updTaken = tk;
    updGhist = gi; updLocalHist = li; restoreValid = doRst; restoreGhist = rv;
    #1;
    chk({ph, " R2 ghist"}, int'(predGhist), int'(ghRef));
    chk({ph, " R4 localHist"}, int'(predLocalHist), int'(lkLh));
    chk({ph, " R5 globalGuess"}, int'(predGlobalTaken), int'(eG));
    chk({ph, " R6 localGuess"}, int'(predLocalTaken), int'(eL));
    chk({ph, " R7 chooser"}, int'(predUseGlobal), int'(eC));
    chk({ph, " R8 final"}, int'(predTaken), int'(eT));
    if (doUpd) begin
      uG = gRef[gi][1];
      uL = lRef[li][2];
      if (uG != uL) cRef[gi] = sat2(cRef[gi], uG == tk);
      gRef[gi] = sat2(gRef[gi], tk);
      lRef[li] = sat3(lRef[li], tk);
      lhtRef[updIdx] = {lhtRef[updIdx][LH-2:0], tk};
    end
    if (doRst) ghRef = rv;
    else if (doUpd) ghRef = {ghRef[GH-2:0], tk};
  endtask

  initial begin
    #1_000_000;
    failCount++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state seen at the ports
    step("R1 reset", 10'd0, 0, 10'd0, 0, 0, '0);
    step("R1 reset", 10'h1ff, 0, 10'd0, 0, 0, '0);
    chk("R1 final after reset", int'(predTaken), 0);

    // R6: local saturation, then a single reversal
    for (int i = 0; i < 14; i++) step("R6 sat", 10'h040, 1, 10'h040, 1, 1, '0);
    step("R6 flip", 10'h040, 1, 10'h040, 0, 1, '0);
    for (int i = 0; i < 4; i++) step("R6 after", 10'h040, 0, 10'h040, 0, 0, '0);

    // R5 and R7: global saturation at a fixed history, components disagree
    for (int i = 0; i < 6; i++) step("R5 sat", 10'h081, 1, 10'h081, 0, 1, 12'h5a5);
    for (int i = 0; i < 6; i++) step("R7 train", 10'h082, 1, 10'h082, (i % 2) == 0, 1, 12'h5a5);

    // R3: restore and update together
    step("R3 both", 10'h010, 1, 10'h010, 1, 1, 12'habc);
    step("R3 check", 10'h010, 0, 10'h010, 0, 0, '0);
    step("R3 restore only", 10'h011, 0, 10'h011, 0, 1, 12'h0f0);
    step("R3 check", 10'h011, 0, 10'h011, 0, 0, '0);

    // R9: lookups only, state must hold
    for (int i = 0; i < 20; i++)
      step("R9 idle", 10'($urandom_range(0, 1023)), 0, 10'd0, 1, 0, '0);

    // R10: random traffic, lookup and update in the same cycle
    for (int i = 0; i < 3000; i++) begin
      logic [LI-1:0] a, b;
      bit t, r;
      a = 10'($urandom_range(0, 15) * 37);
      b = ($urandom_range(0, 3) == 0) ? 10'($urandom_range(0, 15) * 37) : a;
      if (b % 3 == 0) t = 1'b1;
      else if (b % 3 == 1) t = (i % 4) != 3;
      else t = 1'($urandom_range(0, 1));
      r = ($urandom_range(0, 15) == 0);
      step("R10 random", a, $urandom_range(0, 7) != 0, b, t, r, 12'($urandom_range(0, 4095)));
    end

    step("R9 final idle", 10'd0, 0, 10'd0, 0, 0, '0);
    step("R9 final idle", 10'd37, 0, 10'd0, 0, 0, '0);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule